// File: doc/BRIEF.md
# SPI-Slave Configuration Stream Loader

This block is the device-side receiver that takes an FPGA configuration stream from a host over a write-only SPI link. The link has three wires: serial clock, active-low select and serial data in. After reset the block pulls its ready/status line low to invite the host to start. While select is low, the host first clocks a run of zero bits to flush the array. The block looks through that run for a 32-bit synchronization word sent least-significant bit first. A matching word is followed by nine 32-bit words of SoC register data, which are held in a register bank. After those come the configuration payload words, each presented on a memory-style write port with an incrementing word address.

Once the last payload word is in, the host keeps select low and keeps clocking. During this postamble the block drives a chip-reset output for a fixed number of serial clock edges and then raises the status line to report success. A stream whose synchronization word does not match is discarded and reported with a single fixed-length high pulse. A select release before the chip reset has completed leaves the status line low, and the block waits for the next stream.

The serial inputs are oversampled by the system clock. Every register sits in that one clock domain, which also times the mismatch pulse.

Top module: `cfg_rx_loader`

## Requirements
- R1: After reset release, config_o and chip_rst_o are 0 and wr_en_o stays 0 until a payload word completes.
- R2: si_i is sampled on each rising edge of sck_i while cs_ni is 0, and words are assembled with the first received bit at bit 0 (LSB first).
- R3: The synchronization word SYNC_WORD (default 32'h11FF22AA) is found after a zero preamble of any length, including lengths that are not multiples of 32.
- R4: If the 32 bits ending 31 bit times after the first received 1 (32 minus the sync word's trailing-zero count) do not equal SYNC_WORD, the stream is discarded. No write occurs, regs_o is not updated, and config_o goes high for exactly STROBE_CLKS clk_i cycles and then stays low.
- R5: The REG_WORDS words after the sync word are stored in regs_o, with register word n at bits [32n+31:32n].
- R6: Each of the following PAYLOAD_WORDS words produces a single-cycle wr_en_o pulse with wr_data_o equal to the word and wr_addr_o counting from 0 upward by one.
- R7: After the last payload word, chip_rst_o is 1 for RST_CYCLES rising sck_i edges. It then falls, and config_o rises on the next clk_i cycle. The two outputs are never 1 together.
- R8: cs_ni going high before the chip reset completes aborts the load. config_o stays 0, chip_rst_o drops, partial words are not written, and the next low cs_ni starts a fresh sync search.
- R9: After a successful load, config_o stays 1 and further serial traffic causes no writes until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low select from the host |
| si_i | input | 1 | Serial data from the host |
| config_o | output | 1 | Ready/status line: low, mismatch pulse, or high on success |
| chip_rst_o | output | 1 | Array reset issued during the postamble |
| wr_en_o | output | 1 | Payload write strobe |
| wr_addr_o | output | $clog2(PAYLOAD_WORDS) | Payload word address |
| wr_data_o | output | 32 | Payload word |
| regs_o | output | REG_WORDS*32 | SoC register bank |

## Verification
The hardest situations to reach are the ones where the stream ends at an awkward point. One is a select release inside the postamble, after the chip reset has begun but before it completes. Another is a mismatch decision, which falls in the middle of the word that follows a bad sync word. The stimulus reaches these by counting serial edges exactly: it sends the payload, then a chosen number of postamble edges, and then raises select. For the mismatch case, a bad sync word is followed by a short zero tail so that the full pulse width can be measured at the status pin. Preamble lengths of 0, 7, 40 and 20 bits show that the sync search does not depend on word alignment.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_REGS,
    ST_LOAD,
    ST_POST,
    ST_DONE,
    ST_DISCARD
  } ld_state_e;
endpackage

// File: rtl/cfg_rx_frontend.sv
module cfg_rx_frontend #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic cs_act_o
);
  // vector order {sck, cs_n, si}; idle value has select high
  localparam logic [2:0] IDLE_V = 3'b010;

  logic [SYNC_STAGES-1:0][2:0] sync_q;
  logic                        sck_prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= IDLE_V;
        else         sync_q[s] <= {sck_i, cs_ni, si_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= IDLE_V;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sync_q[SYNC_STAGES-1][2];
  end

  assign cs_act_o  = ~sync_q[SYNC_STAGES-1][1];
  assign bit_o     = sync_q[SYNC_STAGES-1][0];
  assign bit_vld_o = sync_q[SYNC_STAGES-1][2] & ~sck_prev_q & cs_act_o;
endmodule

// File: rtl/cfg_rx_sync_hunt.sv
module cfg_rx_sync_hunt #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      SYNC = 32'h11FF22AA
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic match_o,
  output logic miss_o
);
  function automatic int low_one(input logic [W-1:0] v);
    int n;
    n = 0;
    for (int i = W - 1; i >= 0; i--) if (v[i]) n = i;
    return n;
  endfunction

  localparam int unsigned TZ    = low_one(SYNC);
  localparam int unsigned LIMIT = W - TZ;
  localparam int unsigned CW    = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          seen;

  assign sh_n    = {bit_i, sh_q[W-1:1]};
  assign seen    = (cnt_q != '0) || bit_i;
  assign cnt_n   = cnt_q + 1'b1;
  assign match_o = bit_vld_i && (sh_n == SYNC);
  // decision point: the first 1 has travelled to its place in the sync word
  assign miss_o  = bit_vld_i && seen && (cnt_n == CW'(LIMIT)) && !match_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (bit_vld_i) begin
      sh_q <= sh_n;
      if (seen && cnt_q != CW'(LIMIT)) cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/cfg_rx_word_asm.sv
module cfg_rx_word_asm #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  output logic         word_vld_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned BW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [BW-1:0] bit_cnt_q;

  assign word_o     = {bit_i, sh_q[W-1:1]};
  assign word_vld_o = bit_vld_i && (bit_cnt_q == BW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      bit_cnt_q <= '0;
    end else if (clr_i) begin
      bit_cnt_q <= '0;
    end else if (bit_vld_i) begin
      sh_q      <= word_o;
      bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // R2
  cnt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i && !clr_i |=> $stable(bit_cnt_q));
endmodule

// File: rtl/cfg_rx_status.sv
module cfg_rx_status #(
  parameter int unsigned STROBE_CLKS = 375
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic strobe_i,
  output logic config_o
);
  localparam int unsigned SW = $clog2(STROBE_CLKS + 1);

  logic [SW-1:0] strobe_cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_cnt_q <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= done_i;
      if (strobe_i)                strobe_cnt_q <= SW'(STROBE_CLKS);
      else if (strobe_cnt_q != '0) strobe_cnt_q <= strobe_cnt_q - 1'b1;
    end
  end

  assign config_o = done_q | (strobe_cnt_q != '0);

  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> config_o);
endmodule

// File: rtl/cfg_rx_loader.sv
module cfg_rx_loader
  import cfg_rx_pkg::*;
#(
  parameter int unsigned             PAYLOAD_WORDS = 11264,
  parameter int unsigned             REG_WORDS     = 9,
  parameter int unsigned             RST_CYCLES    = 64,
  parameter int unsigned             STROBE_CLKS   = 375,
  parameter int unsigned             SYNC_STAGES   = 2,
  parameter logic [WORD_W-1:0]       SYNC_WORD     = 32'h11FF22AA,
  localparam int unsigned            AW  = (PAYLOAD_WORDS > 1) ? $clog2(PAYLOAD_WORDS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sck_i,
  input  logic                        cs_ni,
  input  logic                        si_i,
  output logic                        config_o,
  output logic                        chip_rst_o,
  output logic                        wr_en_o,
  output logic [AW-1:0]               wr_addr_o,
  output logic [WORD_W-1:0]           wr_data_o,
  output logic [REG_WORDS*WORD_W-1:0] regs_o
);
  localparam int unsigned MAXW = (PAYLOAD_WORDS > REG_WORDS) ? PAYLOAD_WORDS : REG_WORDS;
  localparam int unsigned CW   = $clog2(MAXW) + 1;
  localparam int unsigned RIW  = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1;
  localparam int unsigned PW   = $clog2(RST_CYCLES + 1);

  ld_state_e                            state_q;
  logic [CW-1:0]                        word_cnt_q;
  logic [PW-1:0]                        post_cnt_q;
  logic                                 wr_en_q;
  logic [AW-1:0]                        wr_addr_q;
  logic [WORD_W-1:0]                    wr_data_q;
  logic [REG_WORDS-1:0][WORD_W-1:0]     regs_q;

  logic              bit_vld, bit_val, cs_act;
  logic              hunt_vld, sync_hit, sync_miss;
  logic              asm_clr, word_vld;
  logic [WORD_W-1:0] word;

  cfg_rx_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_i),
    .cs_ni    (cs_ni),
    .si_i     (si_i),
    .bit_vld_o(bit_vld),
    .bit_o    (bit_val),
    .cs_act_o (cs_act)
  );

  assign hunt_vld = bit_vld && (state_q == ST_HUNT);

  cfg_rx_sync_hunt #(.W(WORD_W), .SYNC(SYNC_WORD)) u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_IDLE),
    .bit_vld_i(hunt_vld),
    .bit_i    (bit_val),
    .match_o  (sync_hit),
    .miss_o   (sync_miss)
  );

  assign asm_clr = !(state_q == ST_REGS || state_q == ST_LOAD);

  cfg_rx_word_asm #(.W(WORD_W)) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (asm_clr),
    .bit_vld_i (bit_vld),
    .bit_i     (bit_val),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  cfg_rx_status #(.STROBE_CLKS(STROBE_CLKS)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (state_q == ST_DONE),
    .strobe_i(sync_miss),
    .config_o(config_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      word_cnt_q <= '0;
      post_cnt_q <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      regs_q     <= '0;
    end else begin
      wr_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cs_act) state_q <= ST_HUNT;
        ST_HUNT: begin
          if (!cs_act) state_q <= ST_IDLE;
          else if (sync_hit) begin
            state_q    <= ST_REGS;
            word_cnt_q <= '0;
          end else if (sync_miss) state_q <= ST_DISCARD;
        end
        ST_REGS: begin
          if (!cs_act) state_q <= ST_IDLE;
          else if (word_vld) begin
            regs_q[word_cnt_q[RIW-1:0]] <= word;
            if (word_cnt_q == CW'(REG_WORDS - 1)) begin
              state_q    <= ST_LOAD;
              word_cnt_q <= '0;
            end else word_cnt_q <= word_cnt_q + 1'b1;
          end
        end
        ST_LOAD: begin
          if (!cs_act) state_q <= ST_IDLE;
          else if (word_vld) begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= word_cnt_q[AW-1:0];
            wr_data_q <= word;
            if (word_cnt_q == CW'(PAYLOAD_WORDS - 1)) begin
              state_q    <= ST_POST;
              post_cnt_q <= '0;
            end else word_cnt_q <= word_cnt_q + 1'b1;
          end
        end
        ST_POST: begin
          if (!cs_act) state_q <= ST_IDLE;
          else if (bit_vld) begin
            if (post_cnt_q == PW'(RST_CYCLES - 1)) state_q <= ST_DONE;
            else post_cnt_q <= post_cnt_q + 1'b1;
          end
        end
        ST_DONE: ;
        ST_DISCARD: if (!cs_act) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign chip_rst_o = (state_q == ST_POST);
  assign wr_en_o    = wr_en_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign regs_o     = regs_q;

  // R7
  post_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> !config_o);

  // R6
  wr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R6
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(wr_addr_o) < int'(PAYLOAD_WORDS)));

  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_HUNT, ST_REGS, ST_LOAD, ST_POST}) && !cs_act
      |=> state_q == ST_IDLE);
endmodule

// File: tb/cfg_rx_loader_bench.sv
`timescale 1ns/1ps
module cfg_rx_loader_bench;
  localparam int unsigned PW_N   = 6;
  localparam int unsigned RW_N   = 9;
  localparam int unsigned RST_N  = 8;
  localparam int unsigned STB_N  = 20;
  localparam int unsigned AW     = $clog2(PW_N);
  localparam logic [31:0] SYNC   = 32'h11FF22AA;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic config_o, chip_rst_o, wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic [RW_N*32-1:0] regs_o;

  always #2 clk_i = ~clk_i;

  cfg_rx_loader #(
    .PAYLOAD_WORDS(PW_N), .REG_WORDS(RW_N), .RST_CYCLES(RST_N),
    .STROBE_CLKS(STB_N), .SYNC_WORD(SYNC)
  ) u_cfg_rx_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .config_o(config_o), .chip_rst_o(chip_rst_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .regs_o(regs_o)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [63:0] exp_wr[$];
  logic [RW_N*32-1:0] exp_regs = '0;
  int run_len = 0, last_run = 0;

  task automatic chk(input string req, input logic [RW_N*32-1:0] act, input logic [RW_N*32-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (config_o) run_len++;
      else if (run_len > 0) begin last_run = run_len; run_len = 0; end
      if (chip_rst_o && config_o) begin
        n_err++;
        $display("FAIL R7 actual=chip_rst&config both 1 expected=exclusive");
      end
      if (wr_en_o) begin
        if (exp_wr.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R6 actual=write %0h@%0d expected=no write", wr_data_o, wr_addr_o);
        end else begin
          logic [63:0] e;
          e = exp_wr.pop_front();
          chk("R6 addr", RW_N*32'(wr_addr_o), RW_N*32'(e[63:32]));
          chk("R2 R6 data", RW_N*32'(wr_data_o), RW_N*32'(e[31:0]));
        end
      end
    end
  end

  task automatic settle(); repeat (4) @(negedge clk_i); endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i); si = b;
    repeat (2) @(negedge clk_i); sck = 1'b1;
    repeat (2) @(negedge clk_i); sck = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 32; i++) send_bit(w[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic cs_low(); @(negedge clk_i); cs_n = 1'b0; repeat (4) @(negedge clk_i); endtask
  task automatic cs_high(); @(negedge clk_i); cs_n = 1'b1; sck = 1'b0; repeat (6) @(negedge clk_i); endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    repeat (3) @(negedge clk_i); rst_ni = 1'b1; settle();
    run_len = 0; last_run = 0;
  endtask

  task automatic send_regs(input int n, input logic [31:0] seed);
    for (int j = 0; j < n; j++) begin
      logic [31:0] w;
      w = (32'h11111111 * (j + 1)) ^ seed;
      exp_regs[j*32 +: 32] = w;
      send_word(w);
    end
  endtask

  task automatic send_payload(input int n, input logic [31:0] seed);
    for (int k = 0; k < n; k++) begin
      logic [31:0] w;
      w = (32'hC0DE0000 ^ (32'h01010101 * k)) + seed;
      exp_wr.push_back({32'(k), w});
      send_word(w);
    end
  endtask

  task automatic full_load(input int pre, input logic [31:0] seed);
    cs_low();
    send_zeros(pre);
    send_word(SYNC);
    send_regs(RW_N, seed);
    send_payload(PW_N, seed);
    settle();
    chk("R7 chip_rst after payload", chip_rst_o, 1'b1);
    chk("R5 regs", regs_o, exp_regs);
    send_zeros(RST_N - 1);
    settle();
    chk("R7 chip_rst held", chip_rst_o, 1'b1);
    chk("R7 config low in postamble", config_o, 1'b0);
    send_bit(1'b0);
    settle();
    chk("R7 chip_rst released", chip_rst_o, 1'b0);
    chk("R7 config high", config_o, 1'b1);
    chk("R6 all writes seen", exp_wr.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk("R1 config after reset", config_o, 1'b0);
    chk("R1 chip_rst after reset", chip_rst_o, 1'b0);
    chk("R1 wr_en after reset", wr_en_o, 1'b0);

    // R4: bad sync word, then more traffic that must be ignored
    cs_low();
    send_zeros(20);
    send_word(32'h12345678);
    send_zeros(8);
    settle();
    chk("R4 strobe width", last_run, STB_N);
    chk("R4 config low after strobe", config_o, 1'b0);
    send_word(SYNC);
    for (int j = 0; j < RW_N + PW_N; j++) send_word(32'hA5A50000 + j);
    settle();
    chk("R4 config stays low", config_o, 1'b0);
    chk("R4 regs untouched", regs_o, '0);
    cs_high();

    // R3 R8: after discard, a fresh stream with no preamble loads
    full_load(0, 32'h0000BEEF);
    chk("R4 single strobe", last_run, STB_N);
    do_reset();

    // R8: abort inside register words
    cs_low(); send_zeros(7); send_word(SYNC);
    send_regs(4, 32'h5555AAAA);
    cs_high();
    chk("R8 abort regs config", config_o, 1'b0);
    // R8: abort inside payload, partial word not written
    cs_low(); send_word(SYNC); send_regs(RW_N, 32'h01234567);
    send_payload(3, 32'h01234567);
    send_zeros(10);
    cs_high();
    chk("R8 abort load config", config_o, 1'b0);
    chk("R8 only whole words written", exp_wr.size(), 0);
    // R8: abort inside postamble
    cs_low(); send_zeros(3); send_word(SYNC); send_regs(RW_N, 32'h0F0F0F0F);
    send_payload(PW_N, 32'h0F0F0F0F);
    send_zeros(3);
    settle();
    chk("R8 chip_rst before abort", chip_rst_o, 1'b1);
    cs_high();
    chk("R8 abort post chip_rst", chip_rst_o, 1'b0);
    chk("R8 abort post config", config_o, 1'b0);

    // R3 R5 R6 R7: unaligned preamble
    full_load(40, 32'hDEADBEEF);

    // R9: traffic after success is ignored
    send_word(SYNC);
    for (int j = 0; j < RW_N + 2; j++) send_word(32'h77770000 + j);
    settle();
    chk("R9 config held", config_o, 1'b1);
    cs_high();
    chk("R9 config held after select", config_o, 1'b1);
    chk("R9 regs kept", regs_o, exp_regs);
    do_reset();
    chk("R9 config cleared by reset", config_o, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule